// File: doc/BRIEF.md
# Exception Pending Control Register

This block is a single 32-bit memory-mapped control and status register for a small interrupt controller. It keeps the pending state of three system exceptions: the non-maskable interrupt, a software-deferred service call and the system timer. Software makes an exception pending by writing 1 to its set bit. For the service call and the timer, software withdraws the pending state by writing 1 to a separate clear bit. A write of 0 to any of these bits does nothing.

Hardware clears each pending bit when the core acknowledges entry to that exception's handler. The NMI request line and the timer tick can also set their own pending bits. In the same word, the register reports status that logic outside the block drives: the active exception number, a return-to-base flag, the number of the highest-priority pending exception, an any-interrupt-pending flag and a preemption flag.

The register sits at offset 0xD04. Only privileged accesses reach it. An unprivileged access to that offset gets an error response, changes no state and reads zero. The bus port is single-cycle: read data and the error flag are combinational from the request in the same cycle, and a write takes effect at the next clock edge.

Top module: `exc_pend_ctrl`

## Requirements
- R1: During and after reset all three pending bits are 0. With all status inputs at 0, a privileged read at offset 0xD04 returns 0x0000_0000.
- R2: A request at offset 0xD04 with `priv_i` low raises `err_o`, returns 0 on `rdata_o` and leaves every pending bit unchanged.
- R3: In a privileged write, writing 1 to bit 31 makes the NMI pending from the next cycle on, and writing 0 there leaves it unchanged. Bit 31 reads back the NMI pending state.
- R4: A pulse on `nmi_set_i` makes the NMI pending. `nmi_ack_i` clears it. If a set (hardware or software) and the acknowledge fall in the same cycle, the bit ends up pending.
- R5: In a privileged write, 1 in bit 28 makes the service call pending and 1 in bit 27 clears it. `svc_ack_i` also clears it. Bit 28 reads back the state and bit 27 always reads 0.
- R6: In a privileged write, 1 in bit 26 makes the timer pending and 1 in bit 25 clears it. `tick_set_i` sets it and `tick_ack_i` clears it. Bit 26 reads back the state and bit 25 always reads 0.
- R7: If one write has 1 in both the set and the clear bit of the service call or of the timer, that exception ends up not pending, unless the timer's own hardware set fires in the same cycle.
- R8: A privileged read places the status inputs in these fields: `act_num_i` at bits 8:0, `ret_base_i` at bit 11, `pend_num_i` at bits 19:12, `isr_pend_i` at bit 22 and `preempt_i` at bit 23.
- R9: Bits 30:29, 24, 21:20 and 10:9 always read 0, and writes to them have no effect.
- R10: A request to any offset other than 0xD04 returns 0, does not raise `err_o` and changes no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access valid this cycle |
| addr_i | input | 12 | Byte offset inside the system control space |
| we_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 32 | Write data |
| priv_i | input | 1 | Access comes from privileged mode |
| rdata_o | output | 32 | Read data, combinational |
| err_o | output | 1 | Error response for an unprivileged access |
| nmi_set_i | input | 1 | NMI request pulse |
| tick_set_i | input | 1 | Timer tick sets its pending bit |
| nmi_ack_i | input | 1 | Core entered the NMI handler |
| svc_ack_i | input | 1 | Core entered the service-call handler |
| tick_ack_i | input | 1 | Core entered the timer handler |
| act_num_i | input | 9 | Active exception number |
| ret_base_i | input | 1 | Return-to-base indicator |
| pend_num_i | input | 8 | Highest-priority pending exception number |
| isr_pend_i | input | 1 | Any interrupt pending |
| preempt_i | input | 1 | Preempted active exceptions exist |

## Verification
The assertions assume the acknowledge and hardware-set strobes change only between clock edges and are valid whenever reset is released. The hold properties assume nothing outside the bus port and these strobes moves a pending bit. The bench keeps to that: it changes every input on the falling edge and holds it for a full cycle. The stimulus deliberately covers the collisions the design defines: set with clear in one write, set with acknowledge in one cycle, and hardware set with software clear. It also covers unprivileged and wrongly addressed requests that carry all-ones data.

// File: rtl/exc_pend_pkg.sv
package exc_pend_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned NUM_EXC = 3;

  typedef enum int unsigned {
    EXC_NMI  = 0,
    EXC_SVC  = 1,
    EXC_TICK = 2
  } exc_idx_e;

  // Bit positions decoded by software; keep fixed.
  localparam int unsigned BIT_NMI_SET  = 31;
  localparam int unsigned BIT_SVC_SET  = 28;
  localparam int unsigned BIT_SVC_CLR  = 27;
  localparam int unsigned BIT_TICK_SET = 26;
  localparam int unsigned BIT_TICK_CLR = 25;
  localparam int unsigned BIT_PREEMPT  = 23;
  localparam int unsigned BIT_ISR_PEND = 22;
  localparam int unsigned LSB_PEND_NUM = 12;
  localparam int unsigned BIT_RET_BASE = 11;
endpackage

// File: rtl/exc_pend_dec.sv
module exc_pend_dec
  import exc_pend_pkg::*;
#(
  parameter int unsigned          ADDR_W     = 12,
  parameter logic [ADDR_W-1:0]    REG_OFFSET = 12'hD04
) (
  input  logic                req_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic                priv_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic                hit_o,
  output logic                rd_ok_o,
  output logic                err_o,
  output logic [NUM_EXC-1:0]  set_sw_o,
  output logic [NUM_EXC-1:0]  clr_sw_o
);
  logic wr_ok;

  assign hit_o   = req_i && (addr_i == REG_OFFSET);
  assign err_o   = hit_o && !priv_i;
  assign wr_ok   = hit_o && priv_i && we_i;
  assign rd_ok_o = hit_o && priv_i && !we_i;

  always_comb begin
    set_sw_o = '0;
    clr_sw_o = '0;
    if (wr_ok) begin
      set_sw_o[EXC_NMI]  = wdata_i[BIT_NMI_SET];
      set_sw_o[EXC_SVC]  = wdata_i[BIT_SVC_SET];
      set_sw_o[EXC_TICK] = wdata_i[BIT_TICK_SET];
      clr_sw_o[EXC_SVC]  = wdata_i[BIT_SVC_CLR];
      clr_sw_o[EXC_TICK] = wdata_i[BIT_TICK_CLR];
    end
  end
endmodule

// File: rtl/exc_pend_bit.sv
module exc_pend_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_sw_i,
  input  logic clr_sw_i,
  input  logic set_hw_i,
  input  logic ack_i,
  output logic pend_o
);
  logic sw_set_eff;
  logic pend_d;

  // clear beats set within a write; any set beats handler-entry ack
  assign sw_set_eff = set_sw_i && !clr_sw_i;

  always_comb begin
    pend_d = pend_o;
    if (set_hw_i || sw_set_eff) pend_d = 1'b1;
    else if (clr_sw_i || ack_i) pend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= 1'b0;
    else         pend_o <= pend_d;
  end

  a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_hw_i || (set_sw_i && !clr_sw_i)) |=> pend_o);

  a_r4_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !set_hw_i && !set_sw_i) |=> !pend_o);

  a_r7_clear_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_sw_i && !set_hw_i) |=> !pend_o);

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_sw_i && !clr_sw_i && !set_hw_i && !ack_i) |=> $stable(pend_o));
endmodule

// File: rtl/exc_pend_rd.sv
module exc_pend_rd
  import exc_pend_pkg::*;
#(
  parameter int unsigned ACT_W  = 9,
  parameter int unsigned PEND_W = 8
) (
  input  logic               rd_ok_i,
  input  logic [NUM_EXC-1:0] pend_i,
  input  logic [ACT_W-1:0]   act_num_i,
  input  logic               ret_base_i,
  input  logic [PEND_W-1:0]  pend_num_i,
  input  logic               isr_pend_i,
  input  logic               preempt_i,
  output logic [REG_W-1:0]   rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (rd_ok_i) begin
      rdata_o[ACT_W-1:0]                = act_num_i;
      rdata_o[BIT_RET_BASE]             = ret_base_i;
      rdata_o[LSB_PEND_NUM +: PEND_W]   = pend_num_i;
      rdata_o[BIT_ISR_PEND]             = isr_pend_i;
      rdata_o[BIT_PREEMPT]              = preempt_i;
      rdata_o[BIT_TICK_SET]             = pend_i[EXC_TICK];
      rdata_o[BIT_SVC_SET]              = pend_i[EXC_SVC];
      rdata_o[BIT_NMI_SET]              = pend_i[EXC_NMI];
    end
  end
endmodule

// File: rtl/exc_pend_ctrl.sv
module exc_pend_ctrl
  import exc_pend_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'hD04,
  parameter int unsigned       ACT_W      = 9,
  parameter int unsigned       PEND_W     = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [REG_W-1:0]   wdata_i,
  input  logic               priv_i,
  output logic [REG_W-1:0]   rdata_o,
  output logic               err_o,
  input  logic               nmi_set_i,
  input  logic               tick_set_i,
  input  logic               nmi_ack_i,
  input  logic               svc_ack_i,
  input  logic               tick_ack_i,
  input  logic [ACT_W-1:0]   act_num_i,
  input  logic               ret_base_i,
  input  logic [PEND_W-1:0]  pend_num_i,
  input  logic               isr_pend_i,
  input  logic               preempt_i
);
  logic               hit;
  logic               rd_ok;
  logic [NUM_EXC-1:0] set_sw;
  logic [NUM_EXC-1:0] clr_sw;
  logic [NUM_EXC-1:0] set_hw;
  logic [NUM_EXC-1:0] ack;
  logic [NUM_EXC-1:0] pend;

  assign set_hw = {tick_set_i, 1'b0, nmi_set_i};
  assign ack    = {tick_ack_i, svc_ack_i, nmi_ack_i};

  exc_pend_dec #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_dec (
    .req_i    (req_i),
    .addr_i   (addr_i),
    .we_i     (we_i),
    .priv_i   (priv_i),
    .wdata_i  (wdata_i),
    .hit_o    (hit),
    .rd_ok_o  (rd_ok),
    .err_o    (err_o),
    .set_sw_o (set_sw),
    .clr_sw_o (clr_sw)
  );

  for (genvar i = 0; i < NUM_EXC; i++) begin : g_pend
    exc_pend_bit u_bit (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_sw_i (set_sw[i]),
      .clr_sw_i (clr_sw[i]),
      .set_hw_i (set_hw[i]),
      .ack_i    (ack[i]),
      .pend_o   (pend[i])
    );
  end

  exc_pend_rd #(.ACT_W(ACT_W), .PEND_W(PEND_W)) u_rd (
    .rd_ok_i    (rd_ok),
    .pend_i     (pend),
    .act_num_i  (act_num_i),
    .ret_base_i (ret_base_i),
    .pend_num_i (pend_num_i),
    .isr_pend_i (isr_pend_i),
    .preempt_i  (preempt_i),
    .rdata_o    (rdata_o)
  );

  a_r2_err_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '0));

  a_r2_unpriv_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !priv_i && set_hw == '0 && ack == '0) |=> $stable(pend));

  a_r10_miss_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !hit) |-> (!err_o && rdata_o == '0));

  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (pend == '0));
endmodule

// File: tb/tb_exc_pend_ctrl.sv
`timescale 1ns/1ps
module tb_exc_pend_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 0, we = 0, priv = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic        nmi_set = 0, tick_set = 0, nmi_ack = 0, svc_ack = 0, tick_ack = 0;
  logic [8:0]  act_num = '0;
  logic        ret_base = 0, isr_pend = 0, preempt = 0;
  logic [7:0]  pend_num = '0;

  int total = 0, bad = 0;
  logic m_nmi = 0, m_svc = 0, m_tick = 0;
  localparam logic [11:0] OFF = 12'hD04;

  always #2.5 clk = ~clk;

  exc_pend_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .priv_i(priv), .rdata_o(rdata), .err_o(err),
    .nmi_set_i(nmi_set), .tick_set_i(tick_set), .nmi_ack_i(nmi_ack),
    .svc_ack_i(svc_ack), .tick_ack_i(tick_ack), .act_num_i(act_num),
    .ret_base_i(ret_base), .pend_num_i(pend_num), .isr_pend_i(isr_pend),
    .preempt_i(preempt)
  );

  // behavioural reference, written from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_nmi <= 0; m_svc <= 0; m_tick <= 0;
    end else begin
      bit ok;
      ok = req && addr == OFF && we && priv;
      if (nmi_set || (ok && wdata[31])) m_nmi <= 1;
      else if (nmi_ack) m_nmi <= 0;
      if (ok && wdata[27]) m_svc <= 0;
      else if (ok && wdata[28]) m_svc <= 1;
      else if (svc_ack) m_svc <= 0;
      if (tick_set) m_tick <= 1;
      else if (ok && wdata[25]) m_tick <= 0;
      else if (ok && wdata[26]) m_tick <= 1;
      else if (tick_ack) m_tick <= 0;
    end
  end

  function automatic logic [31:0] exp_rdata();
    logic [31:0] w = '0;
    if (req && addr == OFF && priv && !we) begin
      w[8:0] = act_num; w[11] = ret_base; w[19:12] = pend_num;
      w[22] = isr_pend; w[23] = preempt;
      w[26] = m_tick; w[28] = m_svc; w[31] = m_nmi;
    end
    return w;
  endfunction

  // hw = {tick_ack, svc_ack, nmi_ack, tick_set, nmi_set}
  task automatic step(input string tag, input bit rq, input logic [11:0] ad,
                      input bit w, input logic [31:0] wd, input bit pv,
                      input logic [4:0] hw);
    logic [31:0] e;
    logic ee;
    @(negedge clk);
    req = rq; addr = ad; we = w; wdata = wd; priv = pv;
    {tick_ack, svc_ack, nmi_ack, tick_set, nmi_set} = hw;
    #1;
    e  = exp_rdata();
    ee = rq && ad == OFF && !pv;
    total++;
    if (rdata !== e || err !== ee) begin
      bad++;
      $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b", tag, rdata, err, e, ee);
    end
  endtask

  task automatic rd(input string tag);
    step(tag, 1, OFF, 0, '0, 1, '0);
  endtask

  task automatic wr(input string tag, input logic [31:0] d);
    step(tag, 1, OFF, 1, d, 1, '0);
  endtask

  initial begin
    #20000;
    bad++; total++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rd("R1 in reset");
    rd("R1 in reset");
    @(negedge clk); rst_n = 1;
    rd("R1 after reset");
    // R8 status placement
    act_num = 9'h1A5; ret_base = 1; pend_num = 8'h3C; isr_pend = 1; preempt = 1;
    rd("R8 status fields");
    act_num = 9'h05A; ret_base = 0; pend_num = 8'hC3; isr_pend = 0; preempt = 1;
    rd("R8 status fields alt");
    // R3 NMI
    wr("R3 write zero", 32'h0);
    rd("R3 zero no effect");
    wr("R3 set", 32'h8000_0000);
    rd("R3 nmi pending");
    wr("R3 write zero keeps", 32'h0);
    rd("R3 still pending");
    // R4 ack and collision
    step("R4 ack", 0, OFF, 0, '0, 1, 5'b00100);
    rd("R4 cleared by ack");
    step("R4 hw set", 0, OFF, 0, '0, 1, 5'b00001);
    rd("R4 hw set pending");
    step("R4 set+ack", 0, OFF, 0, '0, 1, 5'b00101);
    rd("R4 set beats ack");
    step("R4 sw set+ack", 1, OFF, 1, 32'h8000_0000, 1, 5'b00100);
    rd("R4 sw set beats ack");
    step("R4 ack again", 0, OFF, 0, '0, 1, 5'b00100);
    // R5 service call
    wr("R5 set", 32'h1000_0000);
    rd("R5 pending");
    wr("R5 clear", 32'h0800_0000);
    rd("R5 cleared");
    wr("R5 set", 32'h1000_0000);
    step("R5 ack", 0, OFF, 0, '0, 1, 5'b01000);
    rd("R5 ack cleared");
    // R6 timer
    wr("R6 set", 32'h0400_0000);
    rd("R6 pending");
    wr("R6 clear", 32'h0200_0000);
    rd("R6 cleared");
    step("R6 hw tick", 0, OFF, 0, '0, 1, 5'b00010);
    rd("R6 tick pending");
    step("R6 ack", 0, OFF, 0, '0, 1, 5'b10000);
    rd("R6 ack cleared");
    step("R6 tick vs sw clr", 1, OFF, 1, 32'h0200_0000, 1, 5'b00010);
    rd("R6 hw tick wins");
    // R7 both bits
    wr("R7 svc set", 32'h1000_0000);
    wr("R7 svc both", 32'h1800_0000);
    rd("R7 svc cleared");
    wr("R7 tick both", 32'h0600_0000);
    rd("R7 tick cleared");
    wr("R7 svc both from idle", 32'h1800_0000);
    rd("R7 svc stays clear");
    // R2 unprivileged
    wr("R2 prep", 32'h9400_0000);
    step("R2 unpriv write", 1, OFF, 1, 32'hFFFF_FFFF, 0, '0);
    step("R2 unpriv read", 1, OFF, 0, '0, 0, '0);
    rd("R2 state kept");
    wr("R2 prep clr", 32'h0A00_0000);
    step("R2 unpriv set", 1, OFF, 1, 32'h1400_0000, 0, '0);
    rd("R2 set ignored");
    // R10 other offset
    step("R10 miss write", 1, 12'hD08, 1, 32'hFFFF_FFFF, 1, '0);
    step("R10 miss read", 1, 12'hD00, 0, '0, 1, '0);
    rd("R10 state kept");
    // R9 reserved
    act_num = '0; pend_num = '0; ret_base = 0; isr_pend = 0; preempt = 0;
    wr("R9 all ones", 32'h6130_0600 | 32'h0100_0000);
    rd("R9 reserved zero");
    wr("R9 full word", 32'hFFFF_FFFF);
    rd("R9 read all");
    step("idle", 0, OFF, 0, '0, 1, '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule